// File: doc/BRIEF.md
# Register-Exchange Survivor and Disagreement Unit

This block holds the survivor history of a four-state soft-output Viterbi decoder by register exchange. Each state owns a path register of `DEPTH` decoded bits. On every valid stage the metric unit supplies one decision bit per end state and the index of the state with the best path metric. The block rebuilds every state's path from the path of its winning predecessor, shifted by one place, with the edge's input bit as the newest entry. No decision memory is kept, and there is no backward walk.

The hard decision is the oldest bit of the best state's rebuilt path. The block also gives, for every state, a `DEPTH`-bit vector with a 1 at each position where the surviving path and the discarded competing path into that state carry different bits. A downstream reliability stage uses this vector to decide which stored reliabilities to update. The hard output is only flagged valid once the path registers hold `DEPTH` real stages.

State numbering follows the code's shift register. State `s = {s1,s0}` is entered with input bit `s1`, and its two predecessors are `{s0,0}` and `{s0,1}`.

Top module: `reg_exchange_hdu`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `hard_bit` and every bit of `diff_all` are 0, and every path register is zero.
- R2: On a valid stage, the newest bit (position 0) of end state s's new path equals bit 1 of s.
- R3: On a valid stage, the winning predecessor of end state s is `{s[0], dec[s]}`. Positions 1 to DEPTH-1 of s's new path equal positions 0 to DEPTH-2 of that predecessor's old path.
- R4: One cycle after a valid stage, `hard_bit` equals position DEPTH-1 (the oldest bit) of the new path of state `best_state`.
- R5: One cycle after a valid stage, `diff_all[s*DEPTH +: DEPTH]` is the XOR of state s's new path and the competing path. The competing path is built from predecessor `{s[0], ~dec[s]}` in the same way as in R2 and R3.
- R6: `out_valid` is high for one cycle after the k-th valid stage since reset only when k >= DEPTH. Otherwise it is low.
- R7: A cycle with `in_valid` low changes no path register and no fill count. It holds `hard_bit` and `diff_all` and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A trellis stage is presented |
| dec | input | 4 | Per end state: low bit of the winning predecessor |
| best_state | input | 2 | State with the best path metric |
| out_valid | output | 1 | `hard_bit` is a decoded bit |
| hard_bit | output | 1 | Oldest bit of the best state's path |
| diff_all | output | 4*DEPTH | Per-state survivor/competitor disagreement |

## Verification
A table of stages walks decision patterns of four kinds: all-zero decisions, all-one decisions, alternating decisions, and mixed decisions with a moving best state. Uniform decisions make paths merge onto a single predecessor, so the disagreement vectors are distinguished from the raw paths. Mixed patterns catch a wrong predecessor index or a reversed shift direction. Directed runs cover the reset state, idle gaps that must freeze the paths, and the exact stage at which `out_valid` first rises.

// File: rtl/hdu_pkg.sv
// Shared constants, types and trellis helpers for the register-exchange unit.
// Assumes a four-state shift-register trellis: state {s1,s0}, input enters s1.
package hdu_pkg;
    localparam int NS = 4;
    localparam int SW = 2;
    typedef logic [SW-1:0] st_t;

    // Predecessor of end state s whose low bit is d.
    function automatic st_t pred_of(input st_t s, input logic d);
        return {s[0], d};
    endfunction

    // Input bit carried by any edge entering end state s.
    function automatic logic edge_bit(input st_t s);
        return s[1];
    endfunction
endpackage

// File: rtl/hdu_trellis_map.sv
// Turns per-state decisions into winner/loser predecessor indices and edge bits.
// Purely combinational; assumes the trellis of hdu_pkg.
module hdu_trellis_map
    import hdu_pkg::*;
(
    input  logic [NS-1:0] dec,
    output st_t           win_idx [NS],
    output st_t           los_idx [NS],
    output logic [NS-1:0] ebit
);
    for (genvar s = 0; s < NS; s++) begin : g_state
        // Resolve both predecessors and the edge input bit for state s.
        always_comb begin
            win_idx[s] = pred_of(st_t'(s), dec[s]);
            los_idx[s] = pred_of(st_t'(s), ~dec[s]);
            ebit[s]    = edge_bit(st_t'(s));
        end
    end
endmodule

// File: rtl/hdu_survivor_bank.sv
// Holds one DEPTH-bit path per state and performs the register exchange.
// Also forms the extended-loser XOR per state. Assumes DEPTH >= 2.
module hdu_survivor_bank
    import hdu_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  st_t              win_idx [NS],
    input  st_t              los_idx [NS],
    input  logic [NS-1:0]    ebit,
    output logic [DEPTH-1:0] path_d  [NS],
    output logic [DEPTH-1:0] diff_d  [NS]
);
    logic [DEPTH-1:0] path_q [NS];

    for (genvar s = 0; s < NS; s++) begin : g_state
        logic [DEPTH-1:0] los_ext;

        // Build the new survivor and the competing path for state s.
        always_comb begin
            path_d[s] = {path_q[win_idx[s]][DEPTH-2:0], ebit[s]};
            los_ext   = {path_q[los_idx[s]][DEPTH-2:0], ebit[s]};
            diff_d[s] = path_d[s] ^ los_ext;
        end

        // Commit the exchanged path on valid stages only.
        always_ff @(posedge clk) begin
            if (!rst_n)        path_q[s] <= '0;
            else if (in_valid) path_q[s] <= path_d[s];
        end

        a_r2_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> path_q[s][0] == s[1]);
        a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(path_q[s]));
    end
endmodule

// File: rtl/hdu_fill_tracker.sv
// Counts valid stages after reset, saturating at DEPTH.
// Reports whether the current valid stage completes a full history.
module hdu_fill_tracker #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic full_now
);
    localparam int CW = $clog2(DEPTH + 1);
    logic [CW-1:0] cnt_q;

    // The current stage is the DEPTH-th or later.
    always_comb full_now = in_valid && (int'(cnt_q) >= DEPTH - 1);

    // Advance the saturating fill count on valid stages.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cnt_q <= '0;
        else if (in_valid && int'(cnt_q) < DEPTH)       cnt_q <= cnt_q + 1'b1;
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= DEPTH);
endmodule

// File: rtl/reg_exchange_hdu.sv
// Top of the register-exchange survivor unit: trellis map, path bank,
// fill tracker and registered outputs (hard bit, validity, disagreements).
// Assumes decisions and best_state belong to the same stage as in_valid.
module reg_exchange_hdu
    import hdu_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [NS-1:0]       dec,
    input  logic [SW-1:0]       best_state,
    output logic                out_valid,
    output logic                hard_bit,
    output logic [NS*DEPTH-1:0] diff_all
);
    st_t              win_idx [NS];
    st_t              los_idx [NS];
    logic [NS-1:0]    ebit;
    logic [DEPTH-1:0] path_d  [NS];
    logic [DEPTH-1:0] diff_d  [NS];
    logic             full_now;
    logic [NS*DEPTH-1:0] diff_flat;

    hdu_trellis_map i_map (
        .dec     (dec),
        .win_idx (win_idx),
        .los_idx (los_idx),
        .ebit    (ebit)
    );

    hdu_survivor_bank #(.DEPTH(DEPTH)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .win_idx  (win_idx),
        .los_idx  (los_idx),
        .ebit     (ebit),
        .path_d   (path_d),
        .diff_d   (diff_d)
    );

    hdu_fill_tracker #(.DEPTH(DEPTH)) i_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .full_now (full_now)
    );

    for (genvar s = 0; s < NS; s++) begin : g_flat
        // Pack state s's disagreement vector into its output slice.
        always_comb diff_flat[s*DEPTH +: DEPTH] = diff_d[s];
    end

    // Register the hard decision, disagreements and validity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hard_bit  <= 1'b0;
            diff_all  <= '0;
        end else begin
            out_valid <= full_now;
            if (in_valid) begin
                hard_bit <= path_d[best_state][DEPTH-1];
                diff_all <= diff_flat;
            end
        end
    end

    a_r6_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(hard_bit) && $stable(diff_all)));
    a_r5_newest_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> diff_all[0] == 1'b0);
endmodule

// File: tb/test_reg_exchange_hdu.sv
module test_reg_exchange_hdu;
    localparam int D  = 8;
    localparam int NS = 4;
    localparam int NV = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [3:0]      dec = '0;
    logic [1:0]      best_state = '0;
    logic            out_valid;
    logic            hard_bit;
    logic [NS*D-1:0] diff_all;

    int n_run = 0;
    int n_fail = 0;

    // Stimulus table: {dec[3:0], best_state[1:0]} per stage.
    localparam logic [5:0] VEC [NV] = '{
        6'b0000_00, 6'b1111_11, 6'b0101_10, 6'b1010_01,
        6'b1100_10, 6'b0011_11, 6'b1001_00, 6'b0110_01,
        6'b1110_11, 6'b0001_10, 6'b1011_00, 6'b0100_01,
        6'b0000_11, 6'b0000_10, 6'b1111_01, 6'b1111_00,
        6'b0101_11, 6'b1010_10, 6'b1101_01, 6'b0010_11,
        6'b0111_00, 6'b1000_10, 6'b0110_11, 6'b1001_01
    };

    // Reference model state
    logic [D-1:0] m_path [NS];
    logic [D*NS-1:0] m_diff;
    logic m_hard;
    int   m_cnt;

    reg_exchange_hdu #(.DEPTH(D)) i_reg_exchange_hdu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec(dec),
        .best_state(best_state), .out_valid(out_valid),
        .hard_bit(hard_bit), .diff_all(diff_all)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) m_path[s] = '0;
        m_diff = '0; m_hard = 1'b0; m_cnt = 0;
    endtask

    // Apply one stage (valid or idle), then check all outputs at the negedge.
    task automatic stage(input logic v, input logic [3:0] d, input logic [1:0] b);
        logic [D-1:0] np [NS];
        logic [D-1:0] lp;
        logic ev;
        in_valid = v; dec = d; best_state = b;
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            for (int s = 0; s < NS; s++) begin
                ev    = s[1];                                  // R2
                np[s] = {m_path[{s[0], d[s]}][D-2:0], ev};     // R3
                lp    = {m_path[{s[0], ~d[s]}][D-2:0], ev};
                m_diff[s*D +: D] = np[s] ^ lp;                 // R5
            end
            for (int s = 0; s < NS; s++) m_path[s] = np[s];
            m_hard = m_path[b][D-1];                           // R4
            if (m_cnt < D) m_cnt++;
        end
        chk(v ? "R6 out_valid" : "R7 idle out_valid", 64'(out_valid),
            64'(v && m_cnt >= D));
        chk(v ? "R4 hard_bit" : "R7 hard hold", 64'(hard_bit), 64'(m_hard));
        chk(v ? "R5 R3 R2 diff" : "R7 diff hold", 64'(diff_all), 64'(m_diff));
        in_valid = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 hard_bit", 64'(hard_bit), 64'd0);
        chk("R1 diff_all", 64'(diff_all), 64'd0);
        rst_n = 1'b1;

        // Table walk, with idle gaps every fifth stage (R7)
        for (int i = 0; i < NV; i++) begin
            stage(1'b1, VEC[i][5:2], VEC[i][1:0]);
            if (i % 5 == 4) stage(1'b0, 4'b1111, 2'b11);
        end

        // Directed: reset again, then check exact fill boundary (R6)
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; model_reset();
        chk("R1 diff after reset", 64'(diff_all), 64'd0);
        for (int i = 0; i < D + 2; i++) begin
            stage(1'b1, 4'b0110, 2'(i));
            if (i == 2) stage(1'b0, 4'b0000, 2'b00);
        end

        // Directed: all-one inputs path then read oldest bit from state 3 (R4)
        for (int i = 0; i < D; i++) stage(1'b1, 4'b1111, 2'b11);
        chk("R4 all-ones oldest", 64'(hard_bit), 64'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule